// File: doc/BRIEF.md
# Inverting bidirectional latched transceiver

This block moves a data word between two ports, A and B. Each direction has its own storage register: one carries A toward B, the other carries B toward A. Each direction also has three active-low controls: a direction enable, a capture control and a drive control. A word always comes out inverted, whichever way it travels.

A direction whose enable is low and whose capture control is low is transparent. Its output follows its input in the same cycle, and its store reloads on every clock edge. When the capture control goes high, the store keeps the value it loaded at the last edge and ignores its input from then on. A port is driven only while that direction's enable and drive control are both low.

Each tri-state port is modelled as three parts: an input word, an output word and a per-bit drive vector. A flag rises whenever both directions drive at once. A synchronous reset clears both stores.

Top module: `inv_latch_xcvr`

## Requirements
- R1: The block holds two independent W-bit stores. `ab_q` carries A toward B and `ba_q` carries B toward A. Changing the controls or the input of one direction never changes the other store or the other output.
- R2: The outputs are inverted in both directions. `b_out` equals the bitwise NOT of the A-to-B view and `a_out` equals the bitwise NOT of the B-to-A view. The view is the input port while transparent, and the store otherwise. The output words carry this value even while undriven.
- R3: While `ab_ce_n` is 1, the A-to-B store keeps its value and `b_drv` is all zeros, whatever `ab_le_n` and `ab_oe_n` are.
- R4: While `ab_ce_n` and `ab_le_n` are both 0, `b_out` follows `~a_in` with no cycle of delay, and the store loads `a_in` at every rising clock edge.
- R5: After `ab_le_n` rises with `ab_ce_n` low, the store keeps the word it loaded at the last edge where `ab_le_n` was 0. Later changes on `a_in` have no effect until `ab_le_n` goes low again.
- R6: `b_drv` is all ones exactly when `ab_ce_n` and `ab_oe_n` are both 0, and all zeros otherwise. No mixed pattern occurs.
- R7: `ab_oe_n` at 1 removes the drive only. The store still loads while `ab_ce_n` and `ab_le_n` are both 0.
- R8: The B-to-A path obeys R3 to R7 with `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `b_in`, `a_out` and `a_drv`.
- R9: `clash` is 1 exactly when `a_drv` and `b_drv` are both nonzero in the same cycle.
- R10: A clock edge with `rst` at 1 clears both stores to zero. During reset, the drive vectors still depend only on the enable inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Word read from port A |
| b_in | input | W | Word read from port B |
| ab_ce_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B capture control, low = transparent |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ba_ce_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A capture control, low = transparent |
| ba_oe_n | input | 1 | B-to-A drive control, active low |
| a_out | output | W | Inverted B-to-A word presented on port A |
| a_drv | output | W | Per-bit drive enable of port A |
| b_out | output | W | Inverted A-to-B word presented on port B |
| b_drv | output | W | Per-bit drive enable of port B |
| clash | output | 1 | Both ports driven at once |

## Verification
The drive vectors, the contention flag and the transparent outputs are combinational, so they are due in the same cycle their inputs change. Store contents become visible one edge later, through the held outputs. The bench changes inputs just after the falling edge and compares outputs 1 ns later. It then advances its own model of both stores just after the rising edge, using the inputs that were stable at that edge. Directed sequences cover freezing on the capture edge, loading with the drive removed, holding while disabled, and reset. Random cycles with a fixed seed cover the remaining control mixes.

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_ce_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  output logic         clash
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_open, ba_open;
  logic         ab_on, ba_on;

  assign ab_open = ~ab_ce_n & ~ab_le_n;
  assign ba_open = ~ba_ce_n & ~ba_le_n;
  assign ab_on   = ~ab_ce_n & ~ab_oe_n;
  assign ba_on   = ~ba_ce_n & ~ba_oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q <= '0;
      ba_q <= '0;
    end else begin
      if (ab_open) ab_q <= a_in;
      if (ba_open) ba_q <= b_in;
    end
  end

  assign b_out = ~(ab_open ? a_in : ab_q);
  assign a_out = ~(ba_open ? b_in : ba_q);
  assign b_drv = {W{ab_on}};
  assign a_drv = {W{ba_on}};
  assign clash = ab_on & ba_on;

endmodule

module inv_latch_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_ce_n,
  input logic         ab_le_n,
  input logic         ab_oe_n,
  input logic         ba_ce_n,
  input logic         ba_le_n,
  input logic         ba_oe_n,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_drv,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_drv,
  input logic         clash,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);

  p_off_undriven_r3: assert property (@(posedge clk) ab_ce_n |-> b_drv == '0);
  p_off_hold_r3: assert property (@(posedge clk) disable iff (rst) ab_ce_n |=> $stable(ab_q));
  p_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_ce_n && !ab_le_n) |-> b_out == ~a_in);
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_ce_n && !ab_le_n) |=> ab_q == $past(a_in));
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst) ab_le_n |=> $stable(ab_q));
  p_held_out_r2: assert property (@(posedge clk) (ab_le_n || ab_ce_n) |-> b_out == ~ab_q);
  p_drive_gate_r6: assert property (@(posedge clk) (b_drv != '0) |-> (!ab_ce_n && !ab_oe_n));
  p_drive_whole_r6: assert property (@(posedge clk) $countones(b_drv) == 0 || $countones(b_drv) == W);
  p_ba_undriven_r8: assert property (@(posedge clk) ba_ce_n |-> a_drv == '0);
  p_ba_freeze_r8: assert property (@(posedge clk) disable iff (rst) (ba_le_n || ba_ce_n) |=> $stable(ba_q));
  p_ba_follow_r8: assert property (@(posedge clk) (!ba_ce_n && !ba_le_n) |-> a_out == ~b_in);
  p_clash_r9: assert property (@(posedge clk) clash |-> (a_drv != '0 && b_drv != '0));
  p_noclash_r9: assert property (@(posedge clk) !clash |-> (a_drv == '0 || b_drv == '0));
  p_reset_r10: assert property (@(posedge clk) rst |=> (ab_q == '0 && ba_q == '0));

endmodule

bind inv_latch_xcvr inv_latch_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
  .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
  .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
  .clash(clash), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/inv_latch_xcvr_bench.sv
`timescale 1ns/1ps
module inv_latch_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;
  logic         clash;

  inv_latch_xcvr #(.W(W)) u_inv_latch_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
    .clash(clash)
  );

  logic [W-1:0] m_ab, m_ba;
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [W-1:0] view(logic ce_n, logic le_n, logic [W-1:0] d, logic [W-1:0] q);
    return (!ce_n && !le_n) ? d : q;
  endfunction

  function automatic logic [W-1:0] drive(logic ce_n, logic oe_n);
    return (!ce_n && !oe_n) ? '1 : '0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic verify();
    check("R2/R4 b_out", b_out, ~view(ab_ce_n, ab_le_n, a_in, m_ab));
    check("R8 a_out", a_out, ~view(ba_ce_n, ba_le_n, b_in, m_ba));
    check("R6 b_drv", b_drv, drive(ab_ce_n, ab_oe_n));
    check("R8 a_drv", a_drv, drive(ba_ce_n, ba_oe_n));
    check("R9 clash", W'(clash), W'((drive(ab_ce_n, ab_oe_n) != 0) && (drive(ba_ce_n, ba_oe_n) != 0)));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (rst) begin
      m_ab = '0;
      m_ba = '0;
    end else begin
      if (!ab_ce_n && !ab_le_n) m_ab = a_in;
      if (!ba_ce_n && !ba_le_n) m_ba = b_in;
    end
    @(negedge clk);
  endtask

  task automatic apply(logic r, logic [W-1:0] a, logic [W-1:0] b,
                       logic ace, logic ale, logic aoe, logic bce, logic ble, logic boe);
    rst = r; a_in = a; b_in = b;
    ab_ce_n = ace; ab_le_n = ale; ab_oe_n = aoe;
    ba_ce_n = bce; ba_le_n = ble; ba_oe_n = boe;
    #1;
    verify();
  endtask

  initial begin
    void'($urandom(32'd1357));
    m_ab = 'x; m_ba = 'x;
    rst = 1'b1; a_in = '0; b_in = '0;
    ab_ce_n = 1; ab_le_n = 1; ab_oe_n = 1; ba_ce_n = 1; ba_le_n = 1; ba_oe_n = 1;
    @(negedge clk);
    #1;
    check("R3 reset b_drv", b_drv, '0);
    check("R8 reset a_drv", a_drv, '0);
    check("R9 reset clash", W'(clash), '0);
    step();
    step();
    // R10: cleared stores seen inverted; drive allowed during reset
    apply(1, 8'h5A, 8'hA5, 0, 1, 0, 0, 1, 0);
    check("R10 held A-to-B after reset", b_out, 8'hFF);
    check("R10 held B-to-A after reset", a_out, 8'hFF);
    step();
    // R4/R5: transparent, then freeze on capture-control rise
    apply(0, 8'h3C, 8'h0F, 0, 0, 0, 1, 1, 1);
    check("R4 transparent", b_out, 8'hC3);
    step();
    apply(0, 8'h99, 8'h0F, 0, 1, 0, 1, 1, 1);
    check("R5 frozen", b_out, 8'hC3);
    step();
    apply(0, 8'h11, 8'h0F, 0, 1, 0, 1, 1, 1);
    step();
    apply(0, 8'h22, 8'h0F, 0, 1, 0, 1, 1, 1);
    check("R5 input ignored", b_out, 8'hC3);
    // R7: load with drive removed
    apply(0, 8'h6E, 8'h0F, 0, 0, 1, 1, 1, 1);
    check("R7 undriven while loading", b_drv, '0);
    step();
    apply(0, 8'h00, 8'h0F, 0, 1, 0, 1, 1, 1);
    check("R7 value loaded", b_out, 8'h91);
    // R3: disabled direction holds
    apply(0, 8'hF0, 8'h0F, 1, 0, 0, 1, 1, 1);
    check("R3 disabled undriven", b_drv, '0);
    step();
    step();
    apply(0, 8'h00, 8'h0F, 0, 1, 0, 1, 1, 1);
    check("R3 held while disabled", b_out, 8'h91);
    // R8 + R1: B-to-A loads, A-to-B untouched
    apply(0, 8'h00, 8'hB4, 0, 1, 0, 0, 0, 0);
    check("R8 transparent", a_out, 8'h4B);
    check("R9 both driving", W'(clash), W'(1));
    step();
    apply(0, 8'h00, 8'h77, 0, 1, 0, 0, 1, 0);
    check("R8 frozen", a_out, 8'h4B);
    check("R1 other store intact", b_out, 8'h91);
    step();
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      apply((($urandom % 64) == 0), W'($urandom), W'($urandom),
            (c[1:0] == 0), c[2], c[3], (c[5:4] == 0), c[6], c[7]);
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule